// File: doc/BRIEF.md
# SPI Flash Address Phase Collector

This block sits behind the serial-to-parallel shifter of an SPI NOR flash slave. While chip select is held low the shifter presents one whole byte at a time. The first byte of a transaction is the opcode. The block classifies it and works out how many address bytes and dummy bytes follow. It then gathers the address bytes into a register, most significant byte first, and counts off the dummy bytes.

When the last byte of the address phase arrives, the block emits a one-cycle indication. The indication carries the final byte address and the phase that comes next: read, page program, erase, or done. An erase also raises an erase request that carries the size of the erase. The surrounding slave supplies the mode inputs: 4-byte address mode, EEPROM mode, the read dummy style, the dummy count and the segment select. The block samples all of them in the cycle that accepts the opcode.

Top module: `spi_addr_collector`

## Requirements
- R1: After reset `phase_valid`, `erase_req` and `collecting` are 0 and `addr_out` is 0.
- R2: Opcodes 0x13, 0x0C, 0x3C, 0x6C, 0xBC, 0xEC, 0x12, 0x21 and 0xDC collect a 4-byte address whatever the value of `addr4_mode`.
- R3: Opcodes 0x03, 0x0B, 0x3B, 0x6B, 0xBB, 0xEB, 0x02, 0xA2, 0x32, 0x20, 0x52 and 0xD8 collect 4 address bytes when `addr4_mode` is 1 and 3 address bytes when it is 0.
- R4: When `eeprom_mode` is 1, every addressed opcode collects exactly 2 address bytes, and no segment offset is added.
- R5: Address bytes are combined most significant byte first. Each new byte shifts the value left by 8 bits. Dummy bytes do not change the address.
- R6: When the address is 3 bytes long, `seg_sel` times 0x1000000 is added to it. 2-byte and 4-byte addresses are output unchanged.
- R7: `rd_style` = 1 adds `dummy_cnt` dummy bytes to opcodes 0x0B/0x0C/0x3B/0x3C/0x6B/0x6C/0xBB/0xBC/0xEB/0xEC. `rd_style` = 0 or 3 adds `dummy_cnt` dummy bytes only to 0xBB/0xBC/0xEB/0xEC. Opcodes 0x03/0x13 never take dummy bytes.
- R8: `rd_style` = 2 makes the dual I/O reads (0xBB/0xBC) collect exactly 4 bytes and the quad I/O reads (0xEB/0xEC) exactly 6 bytes in total. The address bytes come first and the rest are dummy bytes. The fast and output reads get no dummy bytes in this style.
- R9: `phase_valid` pulses for exactly one cycle, in the cycle after the edge that accepts the last address or dummy byte. `phase` is then 1 for reads, 2 for the program opcodes 0x02/0x12/0xA2/0x32, and 3 for erases.
- R10: An erase completion raises `erase_req` together with `phase_valid`. `erase_size` is 0 for 0x20/0x21 (4 KiB), 1 for 0x52 (32 KiB) and 2 for 0xD8/0xDC (full sector).
- R11: A high `cs_n` aborts the transaction at any point. The byte counter is cleared, no indication is issued, and the next low period starts again with an opcode.
- R12: An opcode without an address gives a `phase_valid` pulse with `phase` = 0 one cycle later and leaves `addr_out` unchanged. Bytes that arrive after any completion are ignored until `cs_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| byte_valid | input | 1 | A whole byte is present on `byte_in` this cycle |
| byte_in | input | 8 | Byte from the shifter |
| addr4_mode | input | 1 | 4-byte address mode flag |
| eeprom_mode | input | 1 | Fixed 2-byte address mode |
| rd_style | input | 2 | Dummy rule: 0/3 plain, 1 count-based, 2 fixed totals |
| dummy_cnt | input | 4 | Dummy byte count from the configuration |
| seg_sel | input | 2 | 16 MiB segment for 3-byte addresses |
| collecting | output | 1 | Address or dummy bytes are being gathered |
| phase_valid | output | 1 | One-cycle end-of-address-phase strobe |
| phase | output | 2 | Next phase: 0 done, 1 read, 2 program, 3 erase |
| addr_out | output | ADDR_W | Final byte address |
| erase_req | output | 1 | Erase request strobe |
| erase_size | output | 2 | 0 4 KiB, 1 32 KiB, 2 sector |

## Verification
The assertions assume that `byte_valid` carries meaning only while `cs_n` is low. They also assume that the mode inputs are steady from the opcode byte to the end of the address phase, because the block latches them at the opcode. The stimulus changes modes only while `cs_n` is high, between transactions. It marks bytes valid only inside a low chip-select window, and it inserts idle gaps in some transactions. A behavioural reference model in the bench, made of integer counters, predicts the strobe, the phase, the erase size and the address on every clock.

// File: rtl/spi_ac_pkg.sv
// Shared types for the SPI address phase collector.
// Assumes an 8-bit opcode and a byte-wide shifter in front of the block.
package spi_ac_pkg;

    // Opcode classes that decide how the address phase is counted
    typedef enum logic [2:0] {
        OC_NONE  = 3'd0,
        OC_READ  = 3'd1,
        OC_FAST  = 3'd2,
        OC_DIO   = 3'd3,
        OC_QIO   = 3'd4,
        OC_PROG  = 3'd5,
        OC_ERASE = 3'd6
    } op_class_e;

    // Next-phase code on the output
    typedef enum logic [1:0] {
        PH_DONE  = 2'd0,
        PH_READ  = 2'd1,
        PH_PROG  = 2'd2,
        PH_ERASE = 2'd3
    } phase_e;

    // Erase granularity
    typedef enum logic [1:0] {
        ER_4K   = 2'd0,
        ER_32K  = 2'd1,
        ER_SECT = 2'd2
    } erase_e;

    // Dummy byte rule
    typedef enum logic [1:0] {
        RS_PLAIN = 2'd0,
        RS_CFG   = 2'd1,
        RS_FIXED = 2'd2
    } rd_style_e;

    // Collector state
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DRAIN   = 2'd2
    } coll_state_e;

    // Decoded opcode attributes
    typedef struct packed {
        op_class_e cls;
        logic      wide;   // always takes a 4-byte address
        erase_e    esz;
    } op_info_t;

    localparam int DIO_FIXED_TOTAL = 4;
    localparam int QIO_FIXED_TOTAL = 6;
    localparam int SEG_SHIFT       = 24;

endpackage

// File: rtl/spi_ac_decode.sv
// Opcode classifier: maps one opcode byte to its class, its forced
// 4-byte flag and its erase size. Purely combinational.
// Assumes unknown opcodes carry no address (class OC_NONE).
module spi_ac_decode
    import spi_ac_pkg::*;
(
    input  logic [7:0] opcode,
    output op_info_t   info
);

    // Opcode lookup
    always_comb begin
        info = '{cls: OC_NONE, wide: 1'b0, esz: ER_4K};
        case (opcode)
            8'h03: info.cls = OC_READ;
            8'h13: begin info.cls = OC_READ;  info.wide = 1'b1; end
            8'h0B, 8'h3B, 8'h6B: info.cls = OC_FAST;
            8'h0C, 8'h3C, 8'h6C: begin info.cls = OC_FAST; info.wide = 1'b1; end
            8'hBB: info.cls = OC_DIO;
            8'hBC: begin info.cls = OC_DIO;   info.wide = 1'b1; end
            8'hEB: info.cls = OC_QIO;
            8'hEC: begin info.cls = OC_QIO;   info.wide = 1'b1; end
            8'h02, 8'hA2, 8'h32: info.cls = OC_PROG;
            8'h12: begin info.cls = OC_PROG;  info.wide = 1'b1; end
            8'h20: begin info.cls = OC_ERASE; info.esz = ER_4K; end
            8'h21: begin info.cls = OC_ERASE; info.esz = ER_4K;   info.wide = 1'b1; end
            8'h52: begin info.cls = OC_ERASE; info.esz = ER_32K; end
            8'hD8: begin info.cls = OC_ERASE; info.esz = ER_SECT; end
            8'hDC: begin info.cls = OC_ERASE; info.esz = ER_SECT; info.wide = 1'b1; end
            default: info.cls = OC_NONE;
        endcase
    end

endmodule

// File: rtl/spi_ac_len.sv
// Length calculator: from the opcode class and the mode inputs, derives
// the address length and the total bytes of the address phase.
// Assumes the fixed totals are never shorter than the address length.
module spi_ac_len
    import spi_ac_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  op_info_t         info,
    input  logic             addr4_mode,
    input  logic             eeprom_mode,
    input  logic [1:0]       rd_style,
    input  logic [3:0]       dummy_cnt,
    output logic [2:0]       addr_len,
    output logic [CNT_W-1:0] total
);

    localparam logic [CNT_W-1:0] DIO_T = CNT_W'(DIO_FIXED_TOTAL);
    localparam logic [CNT_W-1:0] QIO_T = CNT_W'(QIO_FIXED_TOTAL);

    logic [CNT_W-1:0] alen_w;
    logic [CNT_W-1:0] dummies;
    logic [CNT_W-1:0] cfg_dummies;

    // Address width selection
    always_comb begin
        if (eeprom_mode)
            addr_len = 3'd2;
        else if (info.wide || addr4_mode)
            addr_len = 3'd4;
        else
            addr_len = 3'd3;
    end

    assign alen_w      = CNT_W'(addr_len);
    assign cfg_dummies = CNT_W'(dummy_cnt);

    // Dummy byte count per class and style
    always_comb begin
        dummies = '0;
        case (info.cls)
            OC_FAST: dummies = (rd_style == RS_CFG) ? cfg_dummies : '0;
            OC_DIO:  dummies = (rd_style == RS_FIXED) ? (DIO_T - alen_w) : cfg_dummies;
            OC_QIO:  dummies = (rd_style == RS_FIXED) ? (QIO_T - alen_w) : cfg_dummies;
            default: dummies = '0;
        endcase
    end

    // Total bytes after the opcode
    assign total = alen_w + dummies;

endmodule

// File: rtl/spi_ac_gather.sv
// Byte gatherer: counts accepted bytes and shifts address bytes into an
// accumulator, most significant first; dummy bytes only advance the count.
// Assumes clear has priority and ADDR_W is at least 32.
module spi_ac_gather #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic [7:0]        byte_in,
    input  logic [2:0]        addr_len,
    output logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] acc_nxt
);

    logic [ADDR_W-1:0] acc_q;
    logic              is_addr;

    assign is_addr = (count < CNT_W'(addr_len));

    // Accumulator value including the byte presented this cycle
    always_comb begin
        acc_nxt = acc_q;
        if (take && is_addr)
            acc_nxt = {acc_q[ADDR_W-9:0], byte_in};
    end

    // Counter and accumulator registers
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
            acc_q <= '0;
        end else if (take) begin
            count <= count + 1'b1;
            acc_q <= acc_nxt;
        end
    end

endmodule

// File: rtl/spi_addr_collector.sv
// SPI flash address phase collector (top). Takes the opcode and then the
// address and dummy bytes, and issues a one-cycle next-phase strobe with
// the final address. Mode inputs are sampled with the opcode byte.
// Assumes byte_valid only matters while cs_n is low.
module spi_addr_collector
    import spi_ac_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_in,
    input  logic              addr4_mode,
    input  logic              eeprom_mode,
    input  logic [1:0]        rd_style,
    input  logic [3:0]        dummy_cnt,
    input  logic [1:0]        seg_sel,
    output logic              collecting,
    output logic              phase_valid,
    output logic [1:0]        phase,
    output logic [ADDR_W-1:0] addr_out,
    output logic              erase_req,
    output logic [1:0]        erase_size
);

    coll_state_e       state_q;
    op_info_t          dec_info;
    op_info_t          info_q;
    logic [2:0]        dec_alen;
    logic [CNT_W-1:0]  dec_total;
    logic [2:0]        alen_q;
    logic [CNT_W-1:0]  total_q;
    logic [1:0]        seg_q;
    logic [CNT_W-1:0]  count;
    logic [ADDR_W-1:0] acc_nxt;
    logic [ADDR_W-1:0] final_addr;
    logic              accept;
    logic              take;
    logic              last;
    logic              clear;
    phase_e            done_phase;

    spi_ac_decode u_dec (
        .opcode (byte_in),
        .info   (dec_info)
    );

    spi_ac_len #(.CNT_W(CNT_W)) u_len (
        .info        (dec_info),
        .addr4_mode  (addr4_mode),
        .eeprom_mode (eeprom_mode),
        .rd_style    (rd_style),
        .dummy_cnt   (dummy_cnt),
        .addr_len    (dec_alen),
        .total       (dec_total)
    );

    assign accept = !cs_n && byte_valid;
    assign take   = accept && (state_q == ST_COLLECT);
    assign last   = take && ((count + 1'b1) == total_q);
    assign clear  = cs_n || (state_q != ST_COLLECT);

    spi_ac_gather #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_gat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .take     (take),
        .byte_in  (byte_in),
        .addr_len (alen_q),
        .count    (count),
        .acc_nxt  (acc_nxt)
    );

    // Segment offset applies to 3-byte addresses only
    always_comb begin
        final_addr = acc_nxt;
        if (alen_q == 3'd3)
            final_addr = acc_nxt + ADDR_W'({seg_q, {SEG_SHIFT{1'b0}}});
    end

    // Class to next-phase mapping
    always_comb begin
        case (info_q.cls)
            OC_READ, OC_FAST, OC_DIO, OC_QIO: done_phase = PH_READ;
            OC_PROG:  done_phase = PH_PROG;
            OC_ERASE: done_phase = PH_ERASE;
            default:  done_phase = PH_DONE;
        endcase
    end

    // Transaction state and latched opcode attributes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            info_q  <= '{cls: OC_NONE, wide: 1'b0, esz: ER_4K};
            alen_q  <= 3'd0;
            total_q <= '0;
            seg_q   <= 2'd0;
        end else if (cs_n) begin
            state_q <= ST_IDLE;
        end else if (accept) begin
            case (state_q)
                ST_IDLE: begin
                    info_q  <= dec_info;
                    alen_q  <= dec_alen;
                    total_q <= dec_total;
                    seg_q   <= seg_sel;
                    state_q <= (dec_info.cls == OC_NONE) ? ST_DRAIN : ST_COLLECT;
                end
                ST_COLLECT: if (last) state_q <= ST_DRAIN;
                default: state_q <= state_q;
            endcase
        end
    end

    // Output strobes and held address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_valid <= 1'b0;
            phase       <= PH_DONE;
            addr_out    <= '0;
            erase_req   <= 1'b0;
            erase_size  <= ER_4K;
        end else begin
            phase_valid <= 1'b0;
            erase_req   <= 1'b0;
            if (accept && state_q == ST_IDLE && dec_info.cls == OC_NONE) begin
                phase_valid <= 1'b1;
                phase       <= PH_DONE;
            end else if (last) begin
                phase_valid <= 1'b1;
                phase       <= done_phase;
                addr_out    <= final_addr;
                if (info_q.cls == OC_ERASE) begin
                    erase_req  <= 1'b1;
                    erase_size <= info_q.esz;
                end
            end
        end
    end

    assign collecting = (state_q == ST_COLLECT);

endmodule

// File: rtl/spi_addr_collector_chk.sv
// Protocol checker for the address phase collector, bound to the top.
// Assumes mode inputs are steady during a transaction.
module spi_addr_collector_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              byte_valid,
    input logic              collecting,
    input logic              phase_valid,
    input logic [1:0]        phase,
    input logic [ADDR_W-1:0] addr_out,
    input logic              erase_req,
    input logic [1:0]        erase_size
);

    // R9: strobe lasts one cycle
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        phase_valid |=> !phase_valid);

    // R9: strobe follows an accepted byte
    p_pulse_after_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        phase_valid |-> $past(byte_valid && !cs_n));

    // R10: erase request only with an erase completion
    p_erase_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> (phase_valid && phase == 2'd3));

    // R10: every erase completion requests a legal size
    p_erase_size_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_valid && phase == 2'd3) |-> (erase_req && erase_size != 2'd3));

    // R11: chip select high aborts
    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!phase_valid && !collecting));

    // R12: a done completion leaves the address alone
    p_done_keeps_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_valid && phase == 2'd0) |-> $stable(addr_out));

endmodule

bind spi_addr_collector spi_addr_collector_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_spi_addr_collector.sv
module test_spi_addr_collector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        addr4_mode = 1'b0;
    logic        eeprom_mode = 1'b0;
    logic [1:0]  rd_style = 2'd0;
    logic [3:0]  dummy_cnt = 4'd0;
    logic [1:0]  seg_sel = 2'd0;
    logic        collecting;
    logic        phase_valid;
    logic [1:0]  phase;
    logic [31:0] addr_out;
    logic        erase_req;
    logic [1:0]  erase_size;

    int n_tests = 0;
    int n_fail  = 0;

    spi_addr_collector i_spi_addr_collector (.*);

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: bytes needed per opcode and mode
    function automatic void spec(input logic [7:0] op, output int cls, output int alen,
                                 output int tot, output int esz);
        bit four, fast, io_d, io_q;
        four = 0; fast = 0; io_d = 0; io_q = 0; cls = 0; esz = 0;
        case (op)
            8'h03: cls = 1;
            8'h13: begin cls = 1; four = 1; end
            8'h0B, 8'h3B, 8'h6B: begin cls = 1; fast = 1; end
            8'h0C, 8'h3C, 8'h6C: begin cls = 1; fast = 1; four = 1; end
            8'hBB: begin cls = 1; io_d = 1; end
            8'hBC: begin cls = 1; io_d = 1; four = 1; end
            8'hEB: begin cls = 1; io_q = 1; end
            8'hEC: begin cls = 1; io_q = 1; four = 1; end
            8'h02, 8'hA2, 8'h32: cls = 2;
            8'h12: begin cls = 2; four = 1; end
            8'h20: cls = 3;
            8'h21: begin cls = 3; four = 1; end
            8'h52: begin cls = 3; esz = 1; end
            8'hD8: begin cls = 3; esz = 2; end
            8'hDC: begin cls = 3; esz = 2; four = 1; end
            default: cls = 0;
        endcase
        alen = eeprom_mode ? 2 : ((four || addr4_mode) ? 4 : 3);
        tot = alen;
        if (fast && rd_style == 2'd1) tot = alen + dummy_cnt;
        if (io_d || io_q) begin
            if (rd_style == 2'd2) tot = io_d ? 4 : 6;
            else tot = alen + dummy_cnt;
        end
    endfunction

    // Model state
    int     m_st = 0, m_cnt = 0, m_alen = 0, m_tot = 0, m_cls = 0, m_esz = 0, m_seg = 0;
    longint m_acc = 0;
    bit     m_valid = 0, m_erase = 0;
    int     m_phase = 0, m_esz_out = 0;
    longint m_addr = 0;

    // Reference update on each clock
    always @(posedge clk) begin
        m_valid = 0;
        m_erase = 0;
        if (!rst_n) begin
            m_st = 0; m_addr = 0; m_phase = 0; m_esz_out = 0;
        end else if (cs_n) begin
            m_st = 0;
        end else if (byte_valid) begin
            if (m_st == 0) begin
                spec(byte_in, m_cls, m_alen, m_tot, m_esz);
                m_seg = seg_sel;
                if (m_cls == 0) begin
                    m_valid = 1; m_phase = 0; m_st = 2;
                end else begin
                    m_st = 1; m_cnt = 0; m_acc = 0;
                end
            end else if (m_st == 1) begin
                if (m_cnt < m_alen) m_acc = (m_acc << 8) | byte_in;
                m_cnt++;
                if (m_cnt == m_tot) begin
                    m_valid = 1;
                    m_phase = m_cls;
                    m_addr = (m_acc + ((m_alen == 3) ? m_seg * 64'h1000000 : 0)) & 64'hFFFF_FFFF;
                    if (m_cls == 3) begin m_erase = 1; m_esz_out = m_esz; end
                    m_st = 2;
                end
            end
        end
    end

    // Captured completion and per-clock comparison
    int     npulse = 0;
    longint cap_addr = 0;
    int     cap_phase = 0, cap_esz = 0;
    bit     run_cmp = 0;

    always @(negedge clk) begin
        if (run_cmp) begin
            chk(phase_valid == m_valid, "R9 strobe timing", phase_valid, m_valid);
            chk(erase_req == m_erase, "R10 erase strobe", erase_req, m_erase);
            chk(addr_out == m_addr[31:0], "R5 address vs model", addr_out, m_addr);
            if (m_valid) chk(phase == m_phase, "R9 phase vs model", phase, m_phase);
            if (m_erase) chk(erase_size == m_esz_out, "R10 size vs model", erase_size, m_esz_out);
        end
        if (phase_valid) begin
            npulse++;
            cap_addr = addr_out; cap_phase = phase; cap_esz = erase_size;
        end
    end

    // One transaction: opcode, n payload bytes MSB first, optional junk, deselect
    task automatic txn(input logic [7:0] op, input int n, input logic [63:0] pl,
                       input bit junk, input bit gaps);
        npulse = 0;
        @(negedge clk);
        cs_n = 0; byte_valid = 1; byte_in = op;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (gaps) begin byte_valid = 0; @(negedge clk); byte_valid = 1; end
            byte_in = pl[63-8*i -: 8];
        end
        @(negedge clk);
        if (junk) begin byte_in = 8'h5A; @(negedge clk); end
        byte_valid = 0;
        @(negedge clk);
        @(negedge clk);
        cs_n = 1;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!phase_valid && !erase_req && !collecting, "R1 reset strobes", phase_valid, 0);
        chk(addr_out == 0, "R1 reset address", addr_out, 0);
        rst_n = 1;
        run_cmp = 1;
        @(negedge clk);

        // R3 / R6: 3-byte read with segment
        seg_sel = 2; addr4_mode = 0;
        txn(8'h03, 3, 64'h123456_0000000000, 1, 0);
        chk(npulse == 1 && cap_addr == 32'h02123456, "R6 segmented 3-byte read", cap_addr, 32'h02123456);
        chk(cap_phase == 1, "R9 read phase", cap_phase, 1);

        // R3: same opcode in 4-byte mode, no segment
        addr4_mode = 1;
        txn(8'h03, 4, 64'h12345678_00000000, 1, 1);
        chk(cap_addr == 32'h12345678, "R3 4-byte mode read", cap_addr, 32'h12345678);

        // R2: forced 4-byte opcode in 3-byte mode
        addr4_mode = 0; seg_sel = 1;
        txn(8'h13, 4, 64'hAABBCCDD_00000000, 1, 0);
        chk(cap_addr == 32'hAABBCCDD, "R2 forced 4-byte read", cap_addr, 32'hAABBCCDD);

        // R2 / R9: forced 4-byte program
        seg_sel = 0;
        txn(8'h12, 4, 64'h00010203_00000000, 1, 0);
        chk(cap_phase == 2 && cap_addr == 32'h00010203, "R9 program phase", cap_phase, 2);

        // R10: erase sizes
        txn(8'h21, 4, 64'h00004000_00000000, 1, 0);
        chk(cap_phase == 3 && cap_esz == 0, "R10 4K erase", cap_esz, 0);
        seg_sel = 1;
        txn(8'h52, 3, 64'h008000_0000000000, 1, 0);
        chk(cap_esz == 1 && cap_addr == 32'h01008000, "R10 32K erase", cap_addr, 32'h01008000);
        addr4_mode = 1;
        txn(8'hD8, 4, 64'h00210000_00000000, 1, 0);
        chk(cap_esz == 2 && cap_addr == 32'h00210000, "R10 sector erase", cap_addr, 32'h00210000);
        addr4_mode = 0;

        // R4: EEPROM mode, 2 bytes, segment ignored
        eeprom_mode = 1; seg_sel = 3;
        txn(8'h13, 2, 64'hBEEF_000000000000, 1, 0);
        chk(npulse == 1 && cap_addr == 32'h0000BEEF, "R4 two-byte address", cap_addr, 32'h0000BEEF);
        eeprom_mode = 0; seg_sel = 0;

        // R7: count-based dummies on fast read
        rd_style = 1; dummy_cnt = 3;
        txn(8'h0B, 6, 64'hABCDEF_FFFFFF_0000, 1, 0);
        chk(npulse == 1 && cap_addr == 32'h00ABCDEF, "R7 fast read with dummies", cap_addr, 32'h00ABCDEF);
        // R7: plain style, fast read has no dummies
        rd_style = 0;
        txn(8'h0B, 3, 64'h010203_0000000000, 1, 0);
        chk(npulse == 1 && cap_addr == 32'h00010203, "R7 plain fast read", cap_addr, 32'h00010203);
        // R7: plain style, dual I/O still adds dummies
        dummy_cnt = 2;
        txn(8'hBB, 5, 64'h0A0B0C_FFFF_000000, 1, 1);
        chk(npulse == 1 && cap_addr == 32'h000A0B0C, "R7 plain dual io", cap_addr, 32'h000A0B0C);

        // R8: fixed totals
        rd_style = 2;
        txn(8'hBB, 4, 64'h112233FF_00000000, 1, 0);
        chk(npulse == 1 && cap_addr == 32'h00112233, "R8 dual io total 4", cap_addr, 32'h00112233);
        txn(8'hEC, 6, 64'h44556677FFFF_0000, 1, 0);
        chk(npulse == 1 && cap_addr == 32'h44556677, "R8 quad io total 6", cap_addr, 32'h44556677);
        rd_style = 0; dummy_cnt = 0;

        // R11: abort part way
        txn(8'h03, 2, 64'h9999_000000000000, 0, 0);
        chk(npulse == 0, "R11 abort gives no strobe", npulse, 0);
        chk(!collecting, "R11 idle after abort", collecting, 0);
        chk(addr_out == 32'h00112233 || addr_out == 32'h44556677, "R11 address held", addr_out, 32'h44556677);
        txn(8'h02, 3, 64'h0000FF_0000000000, 1, 0);
        chk(npulse == 1 && cap_addr == 32'h000000FF, "R11 restart after abort", cap_addr, 32'h000000FF);

        // R12: opcode without address, trailing bytes ignored
        txn(8'h9F, 3, 64'h030303_0000000000, 1, 0);
        chk(npulse == 1 && cap_phase == 0, "R12 done phase once", npulse, 1);
        chk(addr_out == 32'h000000FF, "R12 address unchanged", addr_out, 32'h000000FF);

        run_cmp = 0;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule